// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is the serial control port of a mixed-signal switch. It watches an I2C bus through an oversampled front end. Each line first passes through a two-flop synchronizer and then through a persistence filter, so a pulse shorter than a set number of system clocks never reaches the protocol logic. The block answers at one 7-bit slave address. That address is a fixed base whose two low bits are replaced by a pre-decoded 2-bit strap code, which selects one of four addresses according to how the board ties the strap pin.

After an addressed write, the first byte sets an 8-bit register pointer. Each later byte is stored at the pointer, and the pointer then advances by one. A read uses the combined format: a write that sets only the pointer, a repeated START, and the address with the read bit set. The slave then returns the byte at the pointer and advances the pointer after each byte. The low register offsets are writable control registers, and their contents drive the downstream analog control logic. The next offsets are read-only status bytes supplied from outside. Offsets above those read as zero.

The block drives SDA as an open-drain enable only. It never stretches the clock and does not answer general-call or 10-bit addressing.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset all control register bytes are 0x00 and `sdaPullLow` is 0. While the slave is idle, it never pulls SDA.
- R2: The slave address is `{BASE_ADDR[6:2], strapCode}`, so with the default base 0x48 the strap codes 0, 1, 2 and 3 give 0x48, 0x49, 0x4A and 0x4B. The first byte after a START carries the address in bits 7..1 and R/W in bit 0 (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low in the 9th clock. A non-matching address is not acknowledged, and the slave ignores all bus traffic up to the next START.
- R3: In a write, the byte after the address loads the register pointer. Each following byte is stored at the pointer, after which the pointer increments. Every byte is acknowledged.
- R4: In a combined read (pointer write, repeated START, address with R = 1), the slave shifts out the byte at the pointer MSB first and increments the pointer after each byte. Control offsets 0..NUM_RW-1 return the control registers. Offsets NUM_RW..NUM_RW+NUM_RO-1 return `statusIn` byte (offset-NUM_RW). Higher offsets return 0x00.
- R5: Writes to a read-only or unimplemented offset are acknowledged but change no control register.
- R6: A master NACK after a read byte ends the read. The slave releases SDA and waits for a STOP or START.
- R7: A STOP (SDA rising while SCL is high) at any bit position ends the transfer. A partly received byte is discarded.
- R8: An SDA rise that falls in the same SCL-high phase as the START is not taken as a STOP. The transfer that follows proceeds normally.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks (3 clocks, which is 60 ns at 50 MHz) has no effect on the protocol.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level (bus wired-AND) |
| strapCode | input | 2 | Pre-decoded address strap, replaces address bits 1..0 |
| statusIn | input | NUM_RO*8 | Read-only status bytes, byte k at offset NUM_RW+k |
| sdaPullLow | output | 1 | 1 = pull SDA low (open-drain enable) |
| ctrlRegs | output | NUM_RW*8 | Control register contents, byte k at bits 8k+7..8k |

## Verification
Several properties are checked by assertions on every cycle:
- The filtered line flips only after a steady opposite input.
- The SDA drive stays constant while SCL is high.
- An idle slave never drives SDA.
- A STOP or an address mismatch always returns the FSM to idle.
- The control registers change only on a write strobe.

Other behaviour is shown only by the bench's bus scenarios: the data actually stored and read back under random pointer and length mixes, the per-strap address decoding, discarding a byte cut off by a STOP, ignoring an SDA rise in the START's high phase, and surviving injected glitches.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RACK
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter
    logic loadPtr;   // receive byte becomes register pointer
    logic writeReg;  // receive byte stored at pointer
    logic incPtr;    // pointer advances by one
    logic loadTx;    // transmit shifter loads byte at pointer
    logic shiftTx;   // transmit shifter moves to next bit
  } dpStrobe_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_CYCLES = 3,
  parameter bit RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);

  logic [1:0] syncQ;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {2{RESET_LEVEL}};
    else       syncQ <= {syncQ[0], lineIn};
  end

  // output follows only a level that stayed different for FILT_CYCLES clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut <= RESET_LEVEL;
      runCnt  <= '0;
    end else if (syncQ[1] == lineOut) begin
      runCnt <= '0;
    end else if (runCnt == CNT_W'(FILT_CYCLES - 1)) begin
      lineOut <= syncQ[1];
      runCnt  <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  generate
    if (FILT_CYCLES >= 2) begin : gHoldChk
      // R9
      filt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (lineOut != $past(lineOut)) |-> ($past(syncQ[1]) == lineOut && $past(syncQ[1], 2) == lineOut))
        else $error("filter flipped on a short pulse");
    end
  endgenerate

endmodule

// File: rtl/i2c_slave_datapath.sv
module i2c_slave_datapath
  import i2c_slave_pkg::*;
#(
  parameter int NUM_RW = 6,
  parameter int NUM_RO = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaF,
  input  dpStrobe_t             strb,
  input  logic [NUM_RO*8-1:0]   statusIn,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_RW*8-1:0]   ctrlRegs
);
  logic [7:0] regPtr;
  logic [7:0] txShift;
  logic [7:0] readData;
  logic [7:0] ctrlMem [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxByte <= '0;
    else if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaF};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regPtr <= '0;
    else if (strb.loadPtr) regPtr <= rxByte;
    else if (strb.incPtr)  regPtr <= regPtr + 8'd1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_RW; g++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 ctrlMem[g] <= '0;
        else if (strb.writeReg && regPtr == 8'(g)) ctrlMem[g] <= rxByte;
      end
      assign ctrlRegs[g*8 +: 8] = ctrlMem[g];
    end
  endgenerate

  always_comb begin
    readData = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (regPtr == 8'(i)) readData = ctrlMem[i];
    for (int j = 0; j < NUM_RO; j++)
      if (regPtr == 8'(NUM_RW + j)) readData = statusIn[j*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= 8'hFF;
    else if (strb.loadTx)  txShift <= readData;
    else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  assign txMsb = txShift[7];

  // R5
  ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRegs != $past(ctrlRegs)) |-> $past(strb.writeReg))
    else $error("control register changed without write strobe");

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.incPtr) |-> (regPtr == $past(regPtr) + 8'd1))
    else $error("pointer did not advance");

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [6:0] slaveAddr,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  strb,
  output logic       sdaPullLow
);
  slvState_t state;
  logic [3:0] bitCnt;
  logic sclPrev, sdaPrev, startSeen;
  logic rwBit, ptrPhase, masterAck;
  logic sclRise, sclFall, startCond, stopRaw, stopCond, addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign startCond = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopRaw   = sclF & sclPrev & ~sdaPrev & sdaF;
  assign stopCond  = stopRaw & ~startSeen;
  assign addrHit   = (rxByte[7:1] == slaveAddr);

  // marks the SCL-high phase that carried the START
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          startSeen <= 1'b0;
    else if (startCond) startSeen <= 1'b1;
    else if (sclFall)   startSeen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      ptrPhase  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startCond) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopCond) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) begin
            if (addrHit) begin
              state <= ST_ACK_ADDR;
              rwBit <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (sclFall) begin
            bitCnt   <= '0;
            ptrPhase <= 1'b1;
            state    <= rwBit ? ST_RD : ST_WR;
          end
        end
        ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) state <= ST_ACK_WR;
        end
        ST_ACK_WR: begin
          if (sclFall) begin
            bitCnt   <= '0;
            ptrPhase <= 1'b0;
            state    <= ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) state <= ST_RACK;
        end
        ST_RACK: begin
          if (sclRise) masterAck <= ~sdaF;
          else if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_RD : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic wrByteDone;
  assign wrByteDone = sclFall && state == ST_WR && bitCnt == 4'd8;

  always_comb begin
    strb          = '0;
    strb.shiftIn  = sclRise && (state == ST_ADDR || state == ST_WR);
    strb.loadPtr  = wrByteDone && ptrPhase;
    strb.writeReg = wrByteDone && !ptrPhase;
    strb.incPtr   = (wrByteDone && !ptrPhase) ||
                    (sclFall && state == ST_RD && bitCnt == 4'd8);
    strb.loadTx   = sclFall && ((state == ST_ACK_ADDR && rwBit) ||
                                (state == ST_RACK && masterAck));
    strb.shiftTx  = sclFall && state == ST_RD && bitCnt != 4'd0 && bitCnt < 4'd8;
  end

  assign sdaPullLow = (state == ST_ACK_ADDR) || (state == ST_ACK_WR) ||
                      (state == ST_RD && !txMsb);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow)
    else $error("idle slave drives SDA");

  // R2
  addr_miss_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && bitCnt == 4'd8 && !addrHit && !startCond && !stopCond)
      |=> (state == ST_IDLE))
    else $error("mismatched address not dropped");

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> (state == ST_IDLE))
    else $error("STOP did not end transfer");

  // R8
  start_phase_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopRaw && startSeen) |=> (state == ST_ADDR))
    else $error("STOP honoured in START phase");

  // R10
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF)) |-> (sdaPullLow == $past(sdaPullLow)))
    else $error("SDA drive moved while SCL high");

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPtr, strb.writeReg, strb.loadTx}))
    else $error("conflicting datapath strobes");

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int         NUM_RW      = 6,
  parameter int         NUM_RO      = 2,
  parameter int         FILT_CYCLES = 3,
  parameter logic [6:0] BASE_ADDR   = 7'h48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [1:0]          strapCode,
  input  logic [NUM_RO*8-1:0] statusIn,
  output logic                sdaPullLow,
  output logic [NUM_RW*8-1:0] ctrlRegs
);
  logic [1:0] rawLines;
  logic [1:0] filtLines;
  logic [6:0] slaveAddr;
  logic [7:0] rxByte;
  logic       txMsb;
  dpStrobe_t  strb;

  assign rawLines  = {sdaIn, sclIn};
  assign slaveAddr = {BASE_ADDR[6:2], strapCode};

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : gLine
      i2c_glitch_filter #(.FILT_CYCLES(FILT_CYCLES), .RESET_LEVEL(1'b1)) uFilt (
        .clk(clk), .rstN(rstN), .lineIn(rawLines[k]), .lineOut(filtLines[k])
      );
    end
  endgenerate

  i2c_slave_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclF(filtLines[0]), .sdaF(filtLines[1]),
    .slaveAddr(slaveAddr), .rxByte(rxByte), .txMsb(txMsb),
    .strb(strb), .sdaPullLow(sdaPullLow)
  );

  i2c_slave_datapath #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO)) uDp (
    .clk(clk), .rstN(rstN), .sdaF(filtLines[1]), .strb(strb),
    .statusIn(statusIn), .rxByte(rxByte), .txMsb(txMsb), .ctrlRegs(ctrlRegs)
  );

endmodule

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  localparam int NUM_RW = 6;
  localparam int NUM_RO = 2;
  localparam int Q = 8;
  localparam logic [6:0] BASE = 7'h48;

  logic clk = 0, rstN = 0;
  logic sclDrv = 1, sdaDrv = 1;
  logic [1:0] strapCode = 0;
  logic [NUM_RO*8-1:0] statusIn = 16'hA55A;
  logic sdaPullLow;
  logic [NUM_RW*8-1:0] ctrlRegs;
  logic sdaBus;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2c_reg_slave #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .strapCode(strapCode),
    .statusIn(statusIn), .sdaPullLow(sdaPullLow), .ctrlRegs(ctrlRegs)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, cycles = 0, stableErr = 0;
  bit done = 0;
  logic [7:0] model [NUM_RW];
  logic [7:0] wbuf [16];
  logic gSda = 0, gScl = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input int p);
    if (p < NUM_RW) return model[p];
    if (p < NUM_RW + NUM_RO) return statusIn[(p-NUM_RW)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [6:0] myAddr();
    return {BASE[6:2], strapCode};
  endfunction

  task automatic checkRegs(input string req);
    for (int i = 0; i < NUM_RW; i++) chk(req, int'(ctrlRegs[i*8 +: 8]), int'(model[i]));
  endtask

  task automatic bitIO(input logic b, output logic s);
    logic s2;
    waitQ();
    sdaDrv = b;
    if (gScl) begin
      repeat (2) @(negedge clk); sclDrv = 1;
      repeat (2) @(negedge clk); sclDrv = 0;
      repeat (Q-4) @(negedge clk);
    end else waitQ();
    sclDrv = 1;
    waitQ();
    s = sdaBus;
    if (gSda) begin
      sdaDrv = ~b; repeat (2) @(negedge clk); sdaDrv = b;
    end
    waitQ();
    s2 = sdaBus;
    if (s != s2) stableErr++;
    sclDrv = 0;
  endtask

  task automatic startCond();
    if (!sclDrv) begin
      waitQ(); sdaDrv = 1; waitQ(); sclDrv = 1; waitQ();
    end
    sdaDrv = 0; waitQ(); waitQ(); sclDrv = 0;
  endtask

  task automatic stopCond();
    waitQ(); sdaDrv = 0; waitQ(); sclDrv = 1; waitQ(); sdaDrv = 1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitIO(d[i], s);
    bitIO(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitIO(1'b1, s); d[i] = s; end
    bitIO(~ackIt, s);
  endtask

  task automatic writeTx(input logic [6:0] a, input int ptr, input int n, input string req);
    logic ack;
    logic hit;
    hit = (a == myAddr());
    startCond();
    sendByte({a, 1'b0}, ack);
    chk({req, " R2 addr ack"}, int'(ack), int'(hit));
    if (hit) begin
      sendByte(8'(ptr), ack);
      chk({req, " R3 ptr ack"}, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
        sendByte(wbuf[k], ack);
        chk({req, " R3 data ack"}, int'(ack), 1);
        if (ptr + k < NUM_RW) model[ptr+k] = wbuf[k];
      end
    end
    stopCond();
  endtask

  task automatic readTx(input int ptr, input int n, input string req);
    logic ack;
    logic [7:0] d;
    startCond();
    sendByte({myAddr(), 1'b0}, ack);
    chk({req, " R4 addr ack"}, int'(ack), 1);
    sendByte(8'(ptr), ack);
    startCond();
    sendByte({myAddr(), 1'b1}, ack);
    chk({req, " R4 read addr ack"}, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n-1, d);
      chk({req, " R4 read data"}, int'(d), int'(expRead(ptr + k)));
    end
    waitQ(); waitQ();
    chk({req, " R6 release after master NACK"}, int'(sdaPullLow), 0);
    stopCond();
  endtask

  initial begin
    logic ack;
    logic s;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NUM_RW; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkRegs("R1 reset");
    chk("R1 sda released", int'(sdaPullLow), 0);

    // R2 each strap code, plus a neighbour address that must be ignored
    for (int sc = 0; sc < 4; sc++) begin
      strapCode = 2'(sc);
      wbuf[0] = 8'(8'h10 + sc);
      writeTx(myAddr(), 0, 1, "R2 strap");
      checkRegs("R2 strap write");
      wbuf[0] = 8'hEE;
      writeTx(myAddr() ^ 7'h01, 0, 1, "R2 wrong addr");
      checkRegs("R2 ignored after mismatch");
    end

    // R3 multi-byte burst with auto-increment
    strapCode = 2'd1;
    for (int k = 0; k < NUM_RW; k++) wbuf[k] = 8'(8'hC0 + k);
    writeTx(myAddr(), 0, NUM_RW, "R3 burst");
    checkRegs("R3 burst");

    // R5 writes at read-only and unimplemented offsets
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeTx(myAddr(), NUM_RW, 3, "R5 ro write");
    checkRegs("R5 ro unchanged");
    writeTx(myAddr(), 200, 1, "R5 high write");
    checkRegs("R5 high unchanged");

    // R4 read across control, status and empty offsets
    readTx(NUM_RW - 2, 5, "R4 span");

    // R7 STOP in the middle of a data byte
    startCond();
    sendByte({myAddr(), 1'b0}, ack);
    sendByte(8'd2, ack);
    for (int i = 0; i < 4; i++) bitIO(1'b0, s);
    stopCond();
    checkRegs("R7 partial byte discarded");
    wbuf[0] = 8'h5C;
    writeTx(myAddr(), 2, 1, "R7 after stop");
    checkRegs("R7 next transfer");

    // R8 SDA rise inside the START's SCL-high phase
    sdaDrv = 0; waitQ(); sdaDrv = 1; waitQ(); sclDrv = 0;
    sendByte({myAddr(), 1'b0}, ack);
    chk("R8 addr ack after ignored stop", int'(ack), 1);
    sendByte(8'd3, ack);
    sendByte(8'h9D, ack);
    model[3] = 8'h9D;
    stopCond();
    checkRegs("R8 write went through");

    // R9 glitches on SCL low phase and SDA high phase
    gScl = 1; gSda = 1;
    wbuf[0] = 8'h6B; wbuf[1] = 8'hB6;
    writeTx(myAddr(), 4, 2, "R9 glitch");
    gScl = 0; gSda = 0;
    checkRegs("R9 glitch filtered");

    // random mix
    for (int it = 0; it < 12; it++) begin
      int p, n;
      strapCode = 2'($urandom_range(0, 3));
      statusIn = 16'($urandom);
      p = $urandom_range(0, NUM_RW - 1);
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) writeTx(myAddr() ^ 7'(1 << $urandom_range(0, 6)), p, n, "R2 rnd miss");
      else writeTx(myAddr(), p, n, "R3 rnd write");
      checkRegs("R3 rnd regs");
      readTx($urandom_range(0, NUM_RW + NUM_RO + 1), $urandom_range(1, 3), "R4 rnd read");
    end

    chk("R10 SDA stable while SCL high", stableErr, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule